// File: doc/BRIEF.md
# Video Test Pattern Generator with Loop-Back Self-Test

This block produces a stream of 10-bit component video words for a chosen test pattern. The pattern is flat black, a clock-recovery stress pattern, an equalizer stress pattern, or eight full-saturation-free colour bars. A 4-bit selection code picks the pattern, the line standard (NTSC or PAL line count) and the raster width (4:3 or 16:9 active words). The code is presented on the low four bits of the parallel data input. Generation begins once the enable is high, the upstream clock is locked and the upper six data bits are zero. The words leave on a valid/ready stream. The valid signal stays high for the whole run. A word is replaced only when the consumer accepts it, so back-pressure simply freezes the raster.

For two of the codes the block also runs a self-test. The words that come back through the loop-back path carry no back-pressure and are sampled on every cycle in which the loop-back valid is high. A reference copy of the raster generator steps once for each returned word. Both streams are folded into a 16-bit CRC over each field, and the two CRCs are compared at the field's last word. After two error-free fields the pass flag rises. Any mismatch holds the pass flag low until the enable is removed. Line and field sizes are parameters, not broadcast timing.

Top module: `vidpat_gen`

## Requirements
- R1: After reset, out_valid, pattern_active and pass are all 0.
- R2: A run starts at the first clock edge at which tpg_en=1, lock=1 and data_in[9:4]=0. Without lock, or with any of data_in[9:4] set, no run starts and out_valid stays 0.
- R3: data_in[3:0] is latched when the run starts, and later changes of it are ignored. Dropping lock during a run is also ignored. tpg_en=0 at an edge ends the run: out_valid, pattern_active and pass go to 0. The next run restarts at word 0 of line 0 with field bit 0.
- R4: Every line starts with the words 3FFh, 000h, 000h, then a flag word laid out as {1, F, V, H, V^H, F^H, F^V, F^V^H, 00}. In that flag word H=0, V=1 only on line 0 of a field, and F is the field bit.
- R5: The code bits are laid out as follows. Bit 3 selects 16:9 when set. Bit 2 selects PAL when set. Bits 1:0 give 00 black, 01 clock-stress, 10 equalizer-stress and 11 bars. In active words, index k counts from 0 after the flag word. For black, even k carries 200h and odd k carries 040h.
- R6: The clock-stress pattern puts 300h at even k and 198h at odd k. The equalizer-stress pattern puts 200h at even k and 110h at odd k.
- R7: Bars split the active words into 8 equal bands with abrupt edges, band = k / (active/8). Odd k carries luma Y. k mod 4 = 0 carries Cb, and k mod 4 = 2 carries Cr. Bands 0..7 as Y/Cb/Cr are: 2D0/200/200, 2A0/0B0/220, 24C/26C/0B0, 21C/11C/0D0, 174/2E4/330, 144/194/350, 0F0/350/1E0 and 040/200/200 (hex).
- R8: A line holds 4 + ACT_NARROW words for 4:3 or 4 + ACT_WIDE words for 16:9 (32 and 64 by default). A field holds LINES_NTSC or LINES_PAL lines (4 and 6 by default). F toggles at every field.
- R9: While out_valid=1 and out_ready=0, out_data holds its value. The raster advances by exactly one word per accepted word.
- R10: With codes 0011b and 0101b, pass becomes 1 right after the edge that accepts the last loop-back word of the PASS_FIELDS-th (default 2) field in which both CRCs matched.
- R11: A CRC mismatch at any field end keeps pass at 0 for the rest of the run, even if later fields match. Restarting the run clears this state.
- R12: With any code other than 0011b and 0101b, pass stays 0 and the loop-back inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 10 | Parallel data; bits 3:0 select the pattern, bits 9:4 must be zero |
| tpg_en | input | 1 | Enables generation while high |
| lock | input | 1 | Clock lock indication; required to start |
| out_data | output | 10 | Generated video word |
| out_valid | output | 1 | Word on out_data is valid |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| lb_word | input | 10 | Word returned through the loop-back path |
| lb_valid | input | 1 | lb_word is valid this cycle |
| pattern_active | output | 1 | A run is in progress |
| pass | output | 1 | Self-test has passed |

## Verification
The decisive field-end CRC compare and the exit request can land on the same edge. To provoke this, the bench drops tpg_en in exactly the cycle whose loop-back word completes the second clean field of a self-test. It then judges that pass never shows a 1 and that pattern_active falls, because exit wins. A second concurrency appears when a loop-back word is corrupted early in a field while generation goes on undisturbed. Here the bench checks that the output stream is unaffected and that pass stays low through later clean fields.

// File: rtl/vidpat_pkg.sv
package vidpat_pkg;

  typedef enum logic [1:0] {
    PAT_BLACK = 2'b00,
    PAT_CLKSTRESS = 2'b01,
    PAT_EQSTRESS = 2'b10,
    PAT_BARS = 2'b11
  } pat_e;

  typedef struct packed {
    logic wide;
    logic pal;
    pat_e pat;
  } sel_t;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [9:0] flag_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  function automatic logic [9:0] bar_luma(input logic [2:0] b);
    case (b)
      3'd0: return 10'h2D0;
      3'd1: return 10'h2A0;
      3'd2: return 10'h24C;
      3'd3: return 10'h21C;
      3'd4: return 10'h174;
      3'd5: return 10'h144;
      3'd6: return 10'h0F0;
      default: return 10'h040;
    endcase
  endfunction

  function automatic logic [9:0] bar_chroma(input logic [2:0] b, input logic red_diff);
    case (b)
      3'd1: return red_diff ? 10'h220 : 10'h0B0;
      3'd2: return red_diff ? 10'h0B0 : 10'h26C;
      3'd3: return red_diff ? 10'h0D0 : 10'h11C;
      3'd4: return red_diff ? 10'h330 : 10'h2E4;
      3'd5: return red_diff ? 10'h350 : 10'h194;
      3'd6: return red_diff ? 10'h1E0 : 10'h350;
      default: return 10'h200;
    endcase
  endfunction

  function automatic logic [15:0] crc_fold(input logic [15:0] crc, input logic [9:0] w);
    logic [15:0] c;
    logic fb;
    c = crc;
    for (int i = 0; i < 10; i++) begin
      fb = c[15] ^ w[i];
      c = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

endpackage

// File: rtl/vidpat_raster.sv
module vidpat_raster #(
  parameter int ACT_NARROW = 32,
  parameter int ACT_WIDE = 64,
  parameter int LINES_NTSC = 4,
  parameter int LINES_PAL = 6,
  localparam int WW = $clog2(ACT_WIDE + 4),
  localparam int LMAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC,
  localparam int LW = (LMAX > 1) ? $clog2(LMAX) : 1
) (
  input logic clk,
  input logic rst_n,
  input logic clear,
  input logic step,
  input logic wide,
  input logic pal,
  output logic [WW-1:0] word_idx,
  output logic [LW-1:0] line_idx,
  output logic field_odd
);

  localparam logic [WW-1:0] LASTW_N = WW'(ACT_NARROW + 3);
  localparam logic [WW-1:0] LASTW_W = WW'(ACT_WIDE + 3);
  localparam logic [LW-1:0] LASTL_N = LW'(LINES_NTSC - 1);
  localparam logic [LW-1:0] LASTL_P = LW'(LINES_PAL - 1);

  logic [WW-1:0] last_w;
  logic [LW-1:0] last_l;

  assign last_w = wide ? LASTW_W : LASTW_N;
  assign last_l = pal ? LASTL_P : LASTL_N;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      word_idx <= '0;
      line_idx <= '0;
      field_odd <= 1'b0;
    end else if (step) begin
      if (word_idx == last_w) begin
        word_idx <= '0;
        if (line_idx == last_l) begin
          line_idx <= '0;
          field_odd <= ~field_odd;
        end else begin
          line_idx <= line_idx + 1'b1;
        end
      end else begin
        word_idx <= word_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vidpat_word.sv
module vidpat_word
  import vidpat_pkg::*;
#(
  parameter int ACT_NARROW = 32,
  parameter int ACT_WIDE = 64,
  parameter int LINES_NTSC = 4,
  parameter int LINES_PAL = 6,
  localparam int WW = $clog2(ACT_WIDE + 4),
  localparam int LMAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC,
  localparam int LW = (LMAX > 1) ? $clog2(LMAX) : 1
) (
  input sel_t sel,
  input logic [WW-1:0] word_idx,
  input logic [LW-1:0] line_idx,
  input logic field_odd,
  output logic [9:0] word
);

  localparam logic [WW-1:0] BAND_N = WW'(ACT_NARROW / 8);
  localparam logic [WW-1:0] BAND_W = WW'(ACT_WIDE / 8);

  logic [WW-1:0] k;
  logic [WW-1:0] band_full;
  logic [2:0] band;
  logic [9:0] act_word;

  assign k = word_idx - WW'(4);
  assign band_full = sel.wide ? (k / BAND_W) : (k / BAND_N);
  assign band = band_full[2:0];

  always_comb begin
    case (sel.pat)
      PAT_BLACK: act_word = k[0] ? 10'h040 : 10'h200;
      PAT_CLKSTRESS: act_word = k[0] ? 10'h198 : 10'h300;
      PAT_EQSTRESS: act_word = k[0] ? 10'h110 : 10'h200;
      default: act_word = k[0] ? bar_luma(band) : bar_chroma(band, k[1]);
    endcase
  end

  always_comb begin
    case (word_idx)
      WW'(0): word = 10'h3FF;
      WW'(1), WW'(2): word = 10'h000;
      WW'(3): word = flag_word(field_odd, line_idx == '0, 1'b0);
      default: word = act_word;
    endcase
  end

endmodule

// File: rtl/vidpat_selftest.sv
module vidpat_selftest
  import vidpat_pkg::*;
#(
  parameter int ACT_NARROW = 32,
  parameter int ACT_WIDE = 64,
  parameter int LINES_NTSC = 4,
  parameter int LINES_PAL = 6,
  parameter int PASS_FIELDS = 2,
  localparam int WW = $clog2(ACT_WIDE + 4),
  localparam int LMAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC,
  localparam int LW = (LMAX > 1) ? $clog2(LMAX) : 1,
  localparam int GW = $clog2(PASS_FIELDS + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input sel_t sel,
  input logic [9:0] lb_word,
  input logic lb_valid,
  output logic pass
);

  localparam logic [WW-1:0] LASTW_N = WW'(ACT_NARROW + 3);
  localparam logic [WW-1:0] LASTW_W = WW'(ACT_WIDE + 3);
  localparam logic [LW-1:0] LASTL_N = LW'(LINES_NTSC - 1);
  localparam logic [LW-1:0] LASTL_P = LW'(LINES_PAL - 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(PASS_FIELDS);

  logic [WW-1:0] ref_w;
  logic [LW-1:0] ref_l;
  logic ref_f;
  logic [9:0] ref_word;
  logic field_end;
  logic [15:0] crc_lb, crc_ref, nxt_lb, nxt_ref;
  logic err_q;
  logic [GW-1:0] good_q;

  vidpat_raster #(
    .ACT_NARROW(ACT_NARROW), .ACT_WIDE(ACT_WIDE),
    .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL)
  ) ref_raster_i (
    .clk(clk), .rst_n(rst_n), .clear(!enable), .step(enable && lb_valid),
    .wide(sel.wide), .pal(sel.pal),
    .word_idx(ref_w), .line_idx(ref_l), .field_odd(ref_f)
  );

  vidpat_word #(
    .ACT_NARROW(ACT_NARROW), .ACT_WIDE(ACT_WIDE),
    .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL)
  ) ref_word_i (
    .sel(sel), .word_idx(ref_w), .line_idx(ref_l), .field_odd(ref_f), .word(ref_word)
  );

  assign field_end = (ref_w == (sel.wide ? LASTW_W : LASTW_N)) &&
                     (ref_l == (sel.pal ? LASTL_P : LASTL_N));
  assign nxt_lb = crc_fold(crc_lb, lb_word);
  assign nxt_ref = crc_fold(crc_ref, ref_word);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      crc_lb <= CRC_INIT;
      crc_ref <= CRC_INIT;
      err_q <= 1'b0;
      good_q <= '0;
    end else if (lb_valid) begin
      if (field_end) begin
        crc_lb <= CRC_INIT;
        crc_ref <= CRC_INIT;
        if (nxt_lb != nxt_ref) err_q <= 1'b1;
        else if (good_q != GOOD_MAX) good_q <= good_q + 1'b1;
      end else begin
        crc_lb <= nxt_lb;
        crc_ref <= nxt_ref;
      end
    end
  end

  assign pass = enable && !err_q && (good_q == GOOD_MAX);

endmodule

// File: rtl/vidpat_gen.sv
module vidpat_gen
  import vidpat_pkg::*;
#(
  parameter int ACT_NARROW = 32,
  parameter int ACT_WIDE = 64,
  parameter int LINES_NTSC = 4,
  parameter int LINES_PAL = 6,
  parameter int PASS_FIELDS = 2,
  localparam int WW = $clog2(ACT_WIDE + 4),
  localparam int LMAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC,
  localparam int LW = (LMAX > 1) ? $clog2(LMAX) : 1
) (
  input logic clk,
  input logic rst_n,
  input logic [9:0] data_in,
  input logic tpg_en,
  input logic lock,
  output logic [9:0] out_data,
  output logic out_valid,
  input logic out_ready,
  input logic [9:0] lb_word,
  input logic lb_valid,
  output logic pattern_active,
  output logic pass
);

  logic run_q;
  sel_t sel_q;
  logic code_ok;
  logic st_run;
  logic [WW-1:0] w_idx;
  logic [LW-1:0] l_idx;
  logic f_odd;

  assign code_ok = (data_in[9:4] == 6'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= '0;
    end else if (!tpg_en) begin
      run_q <= 1'b0;
    end else if (!run_q && lock && code_ok) begin
      run_q <= 1'b1;
      sel_q <= sel_t'(data_in[3:0]);
    end
  end

  vidpat_raster #(
    .ACT_NARROW(ACT_NARROW), .ACT_WIDE(ACT_WIDE),
    .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL)
  ) raster_i (
    .clk(clk), .rst_n(rst_n), .clear(!run_q), .step(run_q && out_ready),
    .wide(sel_q.wide), .pal(sel_q.pal),
    .word_idx(w_idx), .line_idx(l_idx), .field_odd(f_odd)
  );

  vidpat_word #(
    .ACT_NARROW(ACT_NARROW), .ACT_WIDE(ACT_WIDE),
    .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL)
  ) word_i (
    .sel(sel_q), .word_idx(w_idx), .line_idx(l_idx), .field_odd(f_odd), .word(out_data)
  );

  assign st_run = run_q && !sel_q.wide &&
                  ((!sel_q.pal && sel_q.pat == PAT_BARS) ||
                   (sel_q.pal && sel_q.pat == PAT_CLKSTRESS));

  vidpat_selftest #(
    .ACT_NARROW(ACT_NARROW), .ACT_WIDE(ACT_WIDE),
    .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL), .PASS_FIELDS(PASS_FIELDS)
  ) selftest_i (
    .clk(clk), .rst_n(rst_n), .enable(st_run), .sel(sel_q),
    .lb_word(lb_word), .lb_valid(lb_valid), .pass(pass)
  );

  assign out_valid = run_q;
  assign pattern_active = run_q;

endmodule

// File: rtl/vidpat_gen_chk.sv
module vidpat_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tpg_en,
  input logic lock,
  input logic [9:0] out_data,
  input logic out_valid,
  input logic out_ready,
  input logic pattern_active,
  input logic pass
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !pattern_active && !pass));

  a_r2_no_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pattern_active && !lock) |=> !pattern_active);

  a_r3_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !tpg_en |=> (!out_valid && !pass));

  a_r4_first_word_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pattern_active) |-> (out_data == 10'h3FF));

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && tpg_en) |=> (out_valid && $stable(out_data)));

  a_r10_pass_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> pattern_active);

endmodule

bind vidpat_gen vidpat_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tpg_en(tpg_en), .lock(lock),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .pattern_active(pattern_active), .pass(pass)
);

// File: tb/vidpat_gen_tb_top.sv
module vidpat_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;
  // {code, position after start, expected word}
  localparam logic [29:0] VEC [NVEC] = '{
    {10'h000, 10'd0,   10'h3FF},  // R4
    {10'h000, 10'd1,   10'h000},  // R4
    {10'h000, 10'd3,   10'h2AC},  // R4 flag word F0 V1
    {10'h000, 10'd4,   10'h200},  // R5
    {10'h000, 10'd5,   10'h040},  // R5
    {10'h000, 10'd39,  10'h200},  // R8 line 1 flag
    {10'h000, 10'd147, 10'h3B0},  // R8 second field flag
    {10'h001, 10'd4,   10'h300},  // R6
    {10'h001, 10'd5,   10'h198},  // R6
    {10'h002, 10'd6,   10'h200},  // R6
    {10'h002, 10'd7,   10'h110},  // R6
    {10'h003, 10'd5,   10'h2D0},  // R7 band 0 luma
    {10'h003, 10'd8,   10'h0B0},  // R7 band 1 Cb
    {10'h003, 10'd10,  10'h220},  // R7 band 1 Cr
    {10'h003, 10'd35,  10'h040},  // R7 band 7 luma
    {10'h00B, 10'd12,  10'h0B0},  // R7 wide band 1
    {10'h00B, 10'd24,  10'h26C},  // R7 wide band 2
    {10'h00B, 10'd71,  10'h200},  // R8 wide line length
    {10'h004, 10'd147, 10'h200},  // R8 PAL line count
    {10'h004, 10'd219, 10'h3B0},  // R8 PAL field end
    {10'h00C, 10'd71,  10'h200},  // R8
    {10'h00C, 10'd411, 10'h3B0}   // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] data_in = '0;
  logic tpg_en = 1'b0;
  logic lock = 1'b0;
  logic out_ready = 1'b1;
  logic corrupt = 1'b0;
  logic [9:0] out_data;
  logic out_valid;
  logic pattern_active;
  logic pass;
  logic [9:0] lb_word;
  logic lb_valid;
  int n_tests = 0;
  int n_fail = 0;
  logic [9:0] held;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign lb_valid = out_valid & out_ready;
  assign lb_word = out_data ^ (corrupt ? 10'h001 : 10'h000);

  vidpat_gen dut_i (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .tpg_en(tpg_en), .lock(lock),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .lb_word(lb_word), .lb_valid(lb_valid),
    .pattern_active(pattern_active), .pass(pass)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [9:0] code);
    tpg_en = 1'b0;
    tick();
    data_in = code;
    lock = 1'b1;
    out_ready = 1'b1;
    tpg_en = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 valid", {9'd0, out_valid}, 10'd0);
    chk("R1 active", {9'd0, pattern_active}, 10'd0);
    chk("R1 pass", {9'd0, pass}, 10'd0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NVEC; i++) begin
      restart(VEC[i][29:20]);
      repeat (int'(VEC[i][19:10])) tick();
      chk("R4 R5 R6 R7 R8 table", out_data, VEC[i][9:0]);
    end

    // R2: no lock, then a bad code, then a good start
    tpg_en = 1'b0; tick();
    lock = 1'b0; data_in = 10'h000; tpg_en = 1'b1;
    repeat (3) tick();
    chk("R2 no lock", {9'd0, out_valid}, 10'd0);
    lock = 1'b1; data_in = 10'h013;
    repeat (3) tick();
    chk("R2 upper bits", {9'd0, pattern_active}, 10'd0);
    data_in = 10'h000;
    tick();
    chk("R2 start", {9'd0, pattern_active}, 10'd1);
    chk("R2 first word", out_data, 10'h3FF);

    // R3: code and lock changes ignored during a run
    data_in = 10'h001; lock = 1'b0;
    repeat (4) tick();
    chk("R3 latched code", out_data, 10'h200);
    chk("R3 lock drop", {9'd0, pattern_active}, 10'd1);
    tpg_en = 1'b0; tick();
    chk("R3 exit", {9'd0, out_valid}, 10'd0);

    // R9: stall holds the word
    restart(10'h000);
    tick();
    out_ready = 1'b0;
    held = out_data;
    repeat (5) tick();
    chk("R9 hold", out_data, held);
    chk("R9 valid", {9'd0, out_valid}, 10'd1);
    out_ready = 1'b1;
    tick();
    chk("R9 advance", out_data, 10'h000);

    // R10: clean self-test, NTSC bars
    restart(10'h003);
    repeat (287) tick();
    chk("R10 before", {9'd0, pass}, 10'd0);
    tick();
    chk("R10 rise", {9'd0, pass}, 10'd1);
    repeat (150) tick();
    chk("R10 stays", {9'd0, pass}, 10'd1);

    // R11: one corrupted loop-back word, then sticky low
    restart(10'h003);
    repeat (10) tick();
    corrupt = 1'b1;
    tick();
    corrupt = 1'b0;
    repeat (500) tick();
    chk("R11 sticky", {9'd0, pass}, 10'd0);
    chk("R11 stream", {9'd0, out_valid}, 10'd1);
    tpg_en = 1'b0; tick();
    chk("R11 cleared", {9'd0, pass}, 10'd0);

    // R10: PAL clock-stress self-test after the error run
    restart(10'h005);
    repeat (431) tick();
    chk("R10 PAL before", {9'd0, pass}, 10'd0);
    tick();
    chk("R10 PAL rise", {9'd0, pass}, 10'd1);

    // R12: non self-test code never passes
    restart(10'h007);
    repeat (500) tick();
    chk("R12 no pass", {9'd0, pass}, 10'd0);

    // R3 and R10 together: exit on the decisive field end
    restart(10'h003);
    repeat (287) tick();
    tpg_en = 1'b0;
    tick();
    chk("R3 exit wins pass", {9'd0, pass}, 10'd0);
    chk("R3 exit wins active", {9'd0, pattern_active}, 10'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule